// File: doc/BRIEF.md
# I2C Passive Bus Monitor

This block listens to the two lines of an I2C bus and turns the traffic into a stream of decoded bytes. Its only bus inputs are SCL and SDA, and it has no output toward the bus, so it can be attached to any bus without affecting it. A system clock much faster than the bus samples both lines. The block is sized so that it keeps up with a 400 kHz bus, where SCL may be high for only about 600 ns.

The block tracks message framing. A start condition opens a message. A stop condition closes it. A repeated start closes the current message and opens a new one. Each byte goes out with its ninth-bit acknowledge value. The first byte of each message is flagged, because that byte holds the 7-bit target address in bits 7:1 and the transfer direction in bit 0 (1 = read, 0 = write).

Decoded bytes leave through a valid/ready port that holds one byte. The bus cannot be stalled, so back-pressure works like this:
- An unaccepted byte stays on the port, with `byte_valid_o` high, until `byte_ready_i` is seen high.
- If a new byte completes while the old one is still waiting, the new byte replaces the old one.

The message strobes are plain one-cycle pulses and do not use the handshake.

Top module: `i2c_bus_sniffer`

## Requirements
- R1: After reset, `byte_valid_o`, `msg_start_o` and `msg_end_o` are all low, and the decoder is idle.
- R2: When SDA falls while SCL is high and no message is open, `msg_start_o` pulses for exactly one cycle.
- R3: The data byte is built from the SDA values captured on the first eight rising SCL edges of the byte. The first value captured is bit 7.
- R4: The SDA value captured on the ninth rising SCL edge goes out on `byte_ack_o`. 0 means acknowledged and 1 means not acknowledged.
- R5: `byte_first_o` is 1 only for the first byte after a start or repeated start. It is 0 for every later byte of the same message.
- R6: When SDA rises while SCL is high inside an open message, `msg_end_o` pulses for one cycle and the decoder goes back to idle.
- R7: A start seen while a message is open is a repeated start. It pulses `msg_end_o`, then pulses `msg_start_o` one cycle later, and the next byte is flagged first. The two strobes are never high in the same cycle.
- R8: A stop or start that arrives before the ninth bit of a byte drops the partial byte. No byte is reported for it.
- R9: A stop condition while idle is ignored. No strobe is raised.
- R10: Once raised, `byte_valid_o` stays high until it is seen together with `byte_ready_i`. A byte that completes while another is still pending overwrites it.
- R11: If a byte completes in the same cycle that a stop or repeated start is detected, the byte is still reported, and the message end is still signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line, asynchronous |
| msg_start_o | output | 1 | One-cycle pulse when a message opens |
| msg_end_o | output | 1 | One-cycle pulse when a message closes |
| byte_valid_o | output | 1 | A decoded byte is on the byte port |
| byte_ready_i | input | 1 | The consumer accepts the byte |
| byte_data_o | output | 8 | Decoded byte, MSB received first |
| byte_ack_o | output | 1 | Ninth bit: 0 ack, 1 nack |
| byte_first_o | output | 1 | Byte is the address/direction byte of its message |

## Verification
The two functions that can fall in the same cycle are completing a byte and detecting a stop or repeated start.

The bench provokes this directly. After the ninth rising SCL edge it raises SDA exactly one system clock later. Both lines pass through identical synchronizers, so the stop is recognised in the very cycle the acknowledge bit is processed.

The result is judged at the ports. The byte must appear with the correct data and acknowledge value, and exactly one `msg_end_o` must follow.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_SAMPLE,
    ST_PROCESS,
    ST_STOP,
    ST_RSTART
  } mon_state_e;

  typedef struct packed {
    logic [BYTE_W-1:0] data;
    logic              ack;
    logic              first;
  } mon_byte_t;
endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // Lines idle high, so reset to 1 to avoid a false edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], line_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2c_mon_framer.sv
module i2c_mon_framer
  import i2c_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      scl_rise_i,
  input  logic      sda_lvl_i,
  input  logic      start_cond_i,
  input  logic      stop_cond_i,
  output logic      msg_start_o,
  output logic      msg_end_o,
  output logic      done_o,
  output mon_byte_t done_byte_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  mon_state_e        state_q, state_d;
  logic [BYTE_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bitcnt_q;
  logic              smp_q;
  logic              first_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_cond_i) state_d = ST_START;
      ST_START,
      ST_SAMPLE,
      ST_PROCESS: begin
        if (start_cond_i)      state_d = ST_RSTART;
        else if (stop_cond_i)  state_d = ST_STOP;
        else if (state_q != ST_SAMPLE || scl_rise_i)
          state_d = (state_q == ST_SAMPLE) ? ST_PROCESS : ST_SAMPLE;
      end
      ST_STOP:    state_d = ST_IDLE;
      ST_RSTART:  state_d = ST_START;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      shreg_q  <= '0;
      bitcnt_q <= '0;
      smp_q    <= 1'b0;
      first_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_START) begin
        bitcnt_q <= '0;
        first_q  <= 1'b1;
      end
      if (state_q == ST_SAMPLE && state_d == ST_PROCESS)
        smp_q <= sda_lvl_i;
      if (state_q == ST_PROCESS) begin
        if (bitcnt_q == LAST_BIT) begin
          bitcnt_q <= '0;
          first_q  <= 1'b0;
        end else begin
          shreg_q  <= {shreg_q[BYTE_W-2:0], smp_q};
          bitcnt_q <= bitcnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o            = (state_q == ST_PROCESS) && (bitcnt_q == LAST_BIT);
  assign done_byte_o.data  = shreg_q;
  assign done_byte_o.ack   = smp_q;
  assign done_byte_o.first = first_q;
  assign msg_start_o       = (state_q == ST_START);
  assign msg_end_o         = (state_q == ST_STOP) || (state_q == ST_RSTART);
endmodule

// File: rtl/i2c_mon_outreg.sv
module i2c_mon_outreg
  import i2c_mon_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  mon_byte_t byte_i,
  input  logic      ready_i,
  output logic      valid_o,
  output mon_byte_t byte_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      byte_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      byte_o  <= byte_i;
    end else if (valid_o && ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bus_sniffer.sv
module i2c_bus_sniffer
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              msg_start_o,
  output logic              msg_end_o,
  output logic              byte_valid_o,
  input  logic              byte_ready_i,
  output logic [BYTE_W-1:0] byte_data_o,
  output logic              byte_ack_o,
  output logic              byte_first_o
);
  localparam int N_LINES = 2;  // index 0 = SCL, 1 = SDA

  logic [N_LINES-1:0] line_in, lvl, rise, fall;
  assign line_in = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2c_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .line_i(line_in[g]),
      .level_o(lvl[g]), .rise_o(rise[g]), .fall_o(fall[g])
    );
  end

  logic scl_steady_hi, start_cond, stop_cond;
  assign scl_steady_hi = lvl[0] & ~rise[0];
  assign start_cond    = fall[1] & scl_steady_hi;
  assign stop_cond     = rise[1] & scl_steady_hi;

  logic      done;
  mon_byte_t done_byte, out_byte;

  i2c_mon_framer u_framer (
    .clk(clk), .rst_n(rst_n),
    .scl_rise_i(rise[0]), .sda_lvl_i(lvl[1]),
    .start_cond_i(start_cond), .stop_cond_i(stop_cond),
    .msg_start_o(msg_start_o), .msg_end_o(msg_end_o),
    .done_o(done), .done_byte_o(done_byte)
  );

  i2c_mon_outreg u_out (
    .clk(clk), .rst_n(rst_n),
    .load_i(done), .byte_i(done_byte), .ready_i(byte_ready_i),
    .valid_o(byte_valid_o), .byte_o(out_byte)
  );

  assign byte_data_o  = out_byte.data;
  assign byte_ack_o   = out_byte.ack;
  assign byte_first_o = out_byte.first;
endmodule

// File: rtl/i2c_mon_chk.sv
module i2c_mon_chk (
  input logic clk,
  input logic rst_n,
  input logic msg_start_o,
  input logic msg_end_o,
  input logic byte_valid_o,
  input logic byte_ready_i
);
  // R2
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start_o |=> !msg_start_o);

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start_o |-> !msg_end_o);

  // R6
  end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_end_o |=> !msg_end_o);

  // R10
  hold_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid_o && !byte_ready_i) |=> byte_valid_o);
endmodule

bind i2c_bus_sniffer i2c_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msg_start_o(msg_start_o), .msg_end_o(msg_end_o),
  .byte_valid_o(byte_valid_o), .byte_ready_i(byte_ready_i)
);

// File: tb/i2c_bus_sniffer_tb.sv
module i2c_bus_sniffer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1, sda = 1'b1, rdy = 1'b1;
  logic ms, me, bv, back, bfirst;
  logic [7:0] bdata;

  always #5 clk = ~clk;

  i2c_bus_sniffer u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
    .msg_start_o(ms), .msg_end_o(me), .byte_valid_o(bv), .byte_ready_i(rdy),
    .byte_data_o(bdata), .byte_ack_o(back), .byte_first_o(bfirst)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;
  int nb, ns, ne;
  logic [7:0] ld [16];
  logic la [16], lf [16];

  always @(negedge clk) if (rst_n) begin
    if (bv && rdy) begin
      if (nb < 16) begin ld[nb] = bdata; la[nb] = back; lf[nb] = bfirst; end
      nb++;
    end
    if (ms) ns++;
    if (me) ne++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam int Q = 4;
  task automatic wq(input int n); repeat (n) @(posedge clk); #1; endtask
  task automatic clr(); nb = 0; ns = 0; ne = 0; endtask

  task automatic b_start(); sda = 1; scl = 1; wq(Q); sda = 0; wq(Q); scl = 0; wq(Q); endtask
  task automatic b_bit(input logic b); sda = b; wq(Q); scl = 1; wq(2*Q); scl = 0; wq(Q); endtask
  task automatic b_stop(); sda = 0; wq(Q); scl = 1; wq(Q); sda = 1; wq(2*Q); endtask
  task automatic b_rstart(); sda = 1; wq(Q); scl = 1; wq(Q); sda = 0; wq(Q); scl = 0; wq(Q); endtask
  task automatic b_byte(input logic [7:0] v, input logic a);
    for (int i = 7; i >= 0; i--) b_bit(v[i]);
    b_bit(a);
  endtask

  initial begin
    clr();
    wq(3);
    // R1 reset state
    chk(!bv && !ms && !me, "R1", {bv, ms, me}, 0);
    rst_n = 1'b1;
    wq(5);
    chk(!bv && ns == 0 && ne == 0, "R1", {bv, ns[0], ne[0]}, 0);

    // Exhaustive sweep: address byte v, data byte ~v, acks from v bits
    for (int v = 0; v < 256; v++) begin
      logic [7:0] vb;
      vb = 8'(v);
      clr();
      b_start(); b_byte(vb, vb[0]); b_byte(~vb, vb[1]); b_stop(); wq(6);
      chk(nb == 2 && ld[0] == vb && ld[1] == ~vb, "R3", {ld[0], ld[1]}, {vb, ~vb});
      chk(la[0] == vb[0] && la[1] == vb[1], "R4", {la[0], la[1]}, {vb[0], vb[1]});
      chk(lf[0] == 1 && lf[1] == 0, "R5", {lf[0], lf[1]}, 2'b10);
      chk(ns == 1 && ne == 1, "R2 R6", {ns[3:0], ne[3:0]}, 8'h11);
    end

    // R7 + R8: repeated start mid-byte drops partial, new message flagged first
    clr();
    b_start(); b_byte(8'hA0, 0);
    for (int i = 0; i < 5; i++) b_bit(1'b1);
    b_rstart(); b_byte(8'hA5, 0); b_byte(8'h3C, 1); b_stop(); wq(6);
    chk(nb == 3, "R8", nb, 3);
    chk(ld[1] == 8'hA5 && lf[1] == 1 && lf[2] == 0, "R7", {ld[1], lf[1], lf[2]}, {8'hA5, 2'b10});
    chk(ns == 2 && ne == 2, "R7", {ns[3:0], ne[3:0]}, 8'h22);

    // R8: stop three bits into a byte
    clr();
    b_start(); b_byte(8'hA4, 0);
    for (int i = 0; i < 3; i++) b_bit(1'b0);
    b_stop(); wq(6);
    chk(nb == 1 && ld[0] == 8'hA4 && ne == 1, "R8", {nb[3:0], ld[0]}, {4'd1, 8'hA4});

    // R9: stop while idle
    clr();
    scl = 0; wq(Q); sda = 0; wq(Q); scl = 1; wq(Q); sda = 1; wq(3*Q);
    chk(ns == 0 && ne == 0 && !bv, "R9", {ns[3:0], ne[3:0]}, 0);

    // R10: back-pressure, newest byte wins
    clr(); rdy = 0;
    b_start(); b_byte(8'h5A, 0); b_byte(8'hC3, 1); b_stop(); wq(6);
    chk(bv && bdata == 8'hC3 && !bfirst && back, "R10", {bv, bdata}, {1'b1, 8'hC3});
    chk(nb == 0, "R10", nb, 0);
    @(negedge clk); rdy = 1; wq(3);
    chk(!bv && nb == 1 && ld[0] == 8'hC3, "R10", {bv, nb[3:0]}, {1'b0, 4'd1});

    // R11: stop detected in the cycle the ack bit is processed
    clr();
    b_start(); b_byte(8'hB1, 0);
    for (int i = 7; i >= 0; i--) b_bit(8'h96 >> i);
    sda = 0; wq(Q);
    scl = 1; wq(1); sda = 1; wq(3*Q);
    chk(nb == 2 && ld[1] == 8'h96 && la[1] == 0, "R11", {nb[3:0], ld[1]}, {4'd2, 8'h96});
    chk(ne == 1 && ns == 1, "R11", {ns[3:0], ne[3:0]}, 8'h11);

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule